// File: doc/BRIEF.md
# Two-to-one word packer for a DMA write path

This block sits between a narrow stream of data words coming out of a source memory and a destination RAM whose write port is twice as wide. It collects narrow words in pairs and writes each pair as one wide word. The wide words go to successive destination addresses, so no narrow word is dropped or cut short. The word that arrives first in a pair goes into the upper half of the wide word, and the word that arrives second goes into the lower half.

The input is a valid/ready stream with a flag that marks the last word of a transfer. When a transfer has an odd number of words, its final word is written straight away with the lower half filled with zeros. A start pulse loads a new destination base address and throws away any half-built word. A one-cycle done pulse follows the final write of each transfer. Every width is a parameter. The destination pointer wraps modulo its width.

Top module: `wp_packer`

## Requirements
- R1: The wide word is 2*NARROW_W bits. For a pair of accepted words A then B, the block writes {A, B}, with A in bits [2*NARROW_W-1:NARROW_W] and B in bits [NARROW_W-1:0].
- R2: A last-flagged word accepted as the first of a pair is written at once as {C, zeros}.
- R3: Each write goes to the address one above the previous write, modulo 2**ADDR_W. The pointer is 0 after reset and equals base_addr after a start pulse.
- R4: wr_en is high in the cycle that follows the clock edge that accepted the second word of a pair, or a last-flagged first word.
- R5: in_ready is low in every cycle in which wr_en is high, so a completed word is never overwritten before it is written.
- R6: done is high for exactly one cycle, in the cycle right after the write of a last-flagged word, and is low at all other times.
- R7: A start pulse discards a half-filled word. The next accepted word then starts a new pair in the upper half.
- R8: A synchronous reset makes wr_en and done low and in_ready high, and discards any half-filled word.
- R9: A transfer of n words produces exactly ceil(n/2) writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load base_addr and discard partial data |
| base_addr | input | ADDR_W | Destination base address loaded by start |
| in_valid | input | 1 | Narrow word present |
| in_ready | output | 1 | Narrow word can be accepted |
| in_data | input | NARROW_W | Narrow word |
| in_last | input | 1 | Marks the final word of a transfer |
| wr_en | output | 1 | Wide write strobe |
| wr_addr | output | ADDR_W | Wide write address |
| wr_data | output | 2*NARROW_W | Wide write data |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
If the half-select flag is wrong, the two halves swap or a word slides into the wrong pair. The wrong data then shows up on wr_data at the very next write. A pending flag that is stuck or lost either shows wr_en for two cycles in a row or leaves in_ready low, and a missing write is counted when the transfer ends. A bad pointer or a leftover half from an earlier transfer shows at the first write after reset or after a start pulse. The bench runs transfers of every length from 1 to 8 with mixed gaps, a transfer that makes the address wrap, and a start and a reset that each land on a half-filled word.

// File: rtl/wp_pkg.sv
package wp_pkg;
   typedef enum logic {
      HALF_UPPER = 1'b0,
      HALF_LOWER = 1'b1
   } half_e;

   localparam int unsigned LANES = 2;
endpackage

// File: rtl/wp_word_buf.sv
module wp_word_buf #(
   parameter int unsigned NARROW_W = 16,
   localparam int unsigned WIDE_W  = NARROW_W * wp_pkg::LANES
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                clr,
   input  logic                load_hi,
   input  logic                load_lo,
   input  logic                zero_lo,
   input  logic [NARROW_W-1:0] din,
   output logic [WIDE_W-1:0]   word
);
   logic [wp_pkg::LANES-1:0] lane_we;
   logic [wp_pkg::LANES-1:0] lane_zero;

   always_comb begin
      lane_we   = '0;
      lane_zero = '0;
      lane_we[wp_pkg::LANES-1] = load_hi;
      lane_we[0]               = load_lo | zero_lo;
      lane_zero[0]             = zero_lo;
   end

   for (genvar g = 0; g < wp_pkg::LANES; g++) begin : g_lane
      logic [NARROW_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (rst || clr)        lane_q <= '0;
         else if (lane_we[g])   lane_q <= lane_zero[g] ? '0 : din;
      end
      assign word[g*NARROW_W +: NARROW_W] = lane_q;
   end

   // R2: a flushed upper-only word carries a zero lower half
   a_r2_lower_zeroed: assert property (@(posedge clk) disable iff (rst)
      zero_lo |=> (word[NARROW_W-1:0] == '0));
endmodule

// File: rtl/wp_dest_ptr.sv
module wp_dest_ptr #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (rst)       ptr <= '0;
      else if (load) ptr <= base;
      else if (adv)  ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/wp_pack_ctl.sv
module wp_pack_ctl
   import wp_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic in_valid,
   input  logic in_last,
   output logic in_ready,
   output logic load_hi,
   output logic load_lo,
   output logic zero_lo,
   output logic wr_en,
   output logic done
);
   half_e half_q;
   logic  pend_q, fin_q, done_q;
   logic  accept;

   assign in_ready = !pend_q && !start;
   assign accept   = in_valid && in_ready;
   assign load_hi  = accept && (half_q == HALF_UPPER);
   assign load_lo  = accept && (half_q == HALF_LOWER);
   assign zero_lo  = load_hi && in_last;
   assign wr_en    = pend_q;
   assign done     = done_q;

   always_ff @(posedge clk) begin
      if (rst || start) begin
         half_q <= HALF_UPPER;
         pend_q <= 1'b0;
         fin_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= pend_q && fin_q;
         if (pend_q) pend_q <= 1'b0;
         if (accept) begin
            if (half_q == HALF_UPPER) begin
               if (in_last) begin
                  pend_q <= 1'b1;
                  fin_q  <= 1'b1;
               end else begin
                  half_q <= HALF_LOWER;
               end
            end else begin
               pend_q <= 1'b1;
               fin_q  <= in_last;
               half_q <= HALF_UPPER;
            end
         end
      end
   end

   // R4: a completed word is written on the next cycle
   a_r4_write_after_fill: assert property (@(posedge clk) disable iff (rst)
      (accept && (half_q == HALF_LOWER || in_last)) |=> wr_en);
   // R5: a word is written once and the port then reopens
   a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en);
   // R6: done only follows a write
   a_r6_done_after_write: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(wr_en));
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R7: start cancels anything in flight
   a_r7_start_quiet: assert property (@(posedge clk) disable iff (rst)
      start |=> (!wr_en && !done));
endmodule

// File: rtl/wp_packer.sv
module wp_packer #(
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned ADDR_W   = 8,
   localparam int unsigned WIDE_W  = NARROW_W * wp_pkg::LANES
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic [ADDR_W-1:0]   base_addr,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [NARROW_W-1:0] in_data,
   input  logic                in_last,
   output logic                wr_en,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [WIDE_W-1:0]   wr_data,
   output logic                done
);
   if (NARROW_W < 1) begin : g_bad_width
      $error("wp_packer: NARROW_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("wp_packer: ADDR_W must be in 1..32");
   end

   logic load_hi, load_lo, zero_lo;

   wp_pack_ctl u_ctl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .in_valid (in_valid),
      .in_last  (in_last),
      .in_ready (in_ready),
      .load_hi  (load_hi),
      .load_lo  (load_lo),
      .zero_lo  (zero_lo),
      .wr_en    (wr_en),
      .done     (done)
   );

   wp_word_buf #(.NARROW_W(NARROW_W)) u_buf (
      .clk     (clk),
      .rst     (rst),
      .clr     (start),
      .load_hi (load_hi),
      .load_lo (load_lo),
      .zero_lo (zero_lo),
      .din     (in_data),
      .word    (wr_data)
   );

   wp_dest_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk  (clk),
      .rst  (rst),
      .load (start),
      .base (base_addr),
      .adv  (wr_en),
      .ptr  (wr_addr)
   );

   // R3: consecutive writes land on consecutive addresses
   a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !start) |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));
   // R5: no input accepted while a wide word waits
   a_r5_ready_blocked: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !in_ready);
endmodule

// File: tb/sim_wp_packer.sv
module sim_wp_packer;
   localparam int NW = 16;
   localparam int AW = 8;
   localparam int WW = 2 * NW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst = 1'b1, start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [NW-1:0] in_data = '0;
   logic          in_ready, wr_en, done;
   logic [AW-1:0] wr_addr;
   logic [WW-1:0] wr_data;

   wp_packer #(.NARROW_W(NW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_last(in_last), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .done(done));

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [WW-1:0] exp_data [0:255];
   logic [AW-1:0] exp_addr [0:255];
   logic          exp_fin  [0:255];
   string         exp_tag  [0:255];
   int            head = 0, tail = 0;
   logic [AW-1:0] nxt_addr = '0;
   logic          prev_fin = 1'b0;
   bit            mon_on = 1'b0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [NW-1:0] word_of(input int tr, input int k);
      return NW'((tr + 1) * 16'h1111) ^ NW'(k * 16'h0203 + 16'h0011);
   endfunction

   // output monitor: data, address, ready hold-off, done timing
   always @(negedge clk) begin
      if (mon_on && !rst) begin
         if (prev_fin || done) check(done === prev_fin, "R6", 64'(done), 64'(prev_fin));
         prev_fin = 1'b0;
         if (wr_en) begin
            check(in_ready === 1'b0, "R5", 64'(in_ready), 64'd0);
            if (tail < head) begin
               check(wr_data === exp_data[tail], exp_tag[tail], 64'(wr_data), 64'(exp_data[tail]));
               check(wr_addr === exp_addr[tail], "R3", 64'(wr_addr), 64'(exp_addr[tail]));
               prev_fin = exp_fin[tail];
               tail++;
            end else begin
               check(1'b0, "R9 extra write", 64'(wr_data), 64'd0);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         check(1'b0, "watchdog", 64'(cyc), 64'd0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // caller is at a negedge; returns at a negedge
   task automatic send(input logic [NW-1:0] d, input logic l, input bit completes,
                       input bit gap);
      in_valid = 1'b1; in_data = d; in_last = l;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (completes) check(wr_en === 1'b1, "R4", 64'(wr_en), 64'd1);
      if (gap) @(negedge clk);
   endtask

   task automatic run_xfer(input int tr, input int n);
      int np;
      np = (n + 1) / 2;
      for (int p = 0; p < np; p++) begin
         logic [NW-1:0] lo;
         lo = (2*p + 1 < n) ? word_of(tr, 2*p + 1) : '0;
         exp_data[head] = {word_of(tr, 2*p), lo};
         exp_addr[head] = nxt_addr;
         exp_fin[head]  = (p == np - 1);
         exp_tag[head]  = (2*p + 1 < n) ? "R1" : "R2";
         nxt_addr = nxt_addr + 1'b1;
         head++;
      end
      @(negedge clk);
      for (int k = 0; k < n; k++)
         send(word_of(tr, k), k == n - 1, (k % 2 == 1) || (k == n - 1), ((k + tr) % 3) == 0);
      repeat (4) @(negedge clk);
      check(tail == head, "R9", 64'(tail), 64'(head));
   endtask

   task automatic pulse_start(input logic [AW-1:0] b);
      @(negedge clk);
      base_addr = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      nxt_addr = b;
      check(wr_en === 1'b0 && done === 1'b0, "R7", {wr_en, done}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      mon_on = 1'b1;
      @(negedge clk);
      check(wr_en === 1'b0, "R8", 64'(wr_en), 64'd0);
      check(done === 1'b0, "R8", 64'(done), 64'd0);
      check(in_ready === 1'b1, "R8", 64'(in_ready), 64'd1);

      // R1 R2 R9: every length 1..8 with mixed gaps
      for (int n = 1; n <= 8; n++) run_xfer(n, n);

      // R3: new base and address wrap
      pulse_start(8'hFE);
      run_xfer(20, 6);

      // R7: start drops a half-filled word
      @(negedge clk);
      send(16'hDEAD, 1'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      check(wr_en === 1'b0, "R7", 64'(wr_en), 64'd0);
      pulse_start(8'h40);
      run_xfer(21, 2);
      run_xfer(22, 3);

      // R8: reset drops a half-filled word and the pointer
      @(negedge clk);
      send(16'hBEEF, 1'b0, 1'b0, 1'b0);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      prev_fin = 1'b0;
      nxt_addr = '0;
      check(wr_en === 1'b0 && done === 1'b0, "R8", {wr_en, done}, 64'd0);
      check(in_ready === 1'b1, "R8", 64'(in_ready), 64'd1);
      run_xfer(23, 3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule